// File: doc/BRIEF.md
# Periodic Wake Watchdog Controller

This block wakes a sleeping host at a fixed period and supervises the host's answer. Time is measured on a slow time base: one tick of `tick_en` stands for 10 ms. At the start of each interval of `interval_len` ticks the block may raise `wake_o` for a short pulse. The host answers with a rising edge on `done_in`. If no answer arrives before a guard window that closes a few ticks ahead of the next interval boundary, the block drives the active-low host reset `host_rst_n_o` for a fixed number of ticks and then starts supervision over again.

The interval length is taken from `interval_len` once, when the startup-busy flag drops. It is held from then on. While startup is busy, or while a manual-reset hold is requested, the host is kept in reset. After a manual hold is released, a full reset pulse runs before the next interval begins. An answer only clears the supervision state. The wake period is measured from the interval boundaries and does not depend on when the answer arrives.

Top module: `wake_watchdog`

## Requirements
- R1: While `rst_n` is low (synchronous reset) with `startup_busy` high, `wake_o` is 0 and `host_rst_n_o` is 0.
- R2: `host_rst_n_o` is 0 on the clock after any cycle with `startup_busy` high. The interval length is captured from `interval_len` on the clock where `startup_busy` is low while the block is still in startup. Later changes of `interval_len` have no effect until `startup_busy` is raised and dropped again.
- R3: No wake pulse is issued at the start of the first interval after startup, or at the start of any interval that follows a reset pulse.
- R4: When an acknowledge was recorded in the interval that just ended, `wake_o` rises on the clock of the boundary tick and stays high for WAKE_TICKS ticks (default 2, i.e. 20 ms).
- R5: An acknowledge is a 0-to-1 transition of `done_in` seen while counting. A level held high across an interval is not an acknowledge. Edges during reset are ignored.
- R6: Only the first acknowledge of an interval is recorded. A second edge in the same interval has no effect on the outputs.
- R7: An acknowledge recorded while `wake_o` is high brings `wake_o` low on the next clock.
- R8: An edge that arrives while the interval position is in the last GUARD_TICKS ticks (default 2, i.e. 20 ms) is not recorded. If no earlier edge was recorded, the interval ends in a reset.
- R9: If an interval ends with no recorded acknowledge, `host_rst_n_o` goes to 0 on the boundary clock and stays 0 for RESET_TICKS ticks (default 32, i.e. 320 ms). It rises on the clock of the last of those ticks, and a new interval starts at position 0.
- R10: While `mr_hold` is 1 (and startup is not busy), `wake_o` and `host_rst_n_o` are 0 from the next clock and the counters are cleared. After release, a full RESET_TICKS reset pulse runs, followed by an interval without a wake pulse.
- R11: While `host_rst_n_o` is high, interval boundaries fall every `interval_len` ticks, whatever the position of the acknowledge within the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-clock enable per 10 ms time-base tick |
| interval_len | input | CNT_W | Interval length in ticks, captured at end of startup |
| done_in | input | 1 | Synchronized host acknowledge; rising edge counts |
| startup_busy | input | 1 | Startup in progress (power-on and interval measurement) |
| mr_hold | input | 1 | Manual-reset hold request |
| wake_o | output | 1 | Wake pulse to the host, active high |
| host_rst_n_o | output | 1 | Host reset, active low |

## Verification
The embedded properties check on every clock that the host is held in reset during startup and manual hold, and that wake never overlaps reset. They also check that a wake edge needs a recorded acknowledge, that a recorded acknowledge drops wake, that the captured length stays fixed, and that both counters stay within range. Exact tick timing can only be shown by the bench scenarios: the 2-tick wake width, the 32-tick reset width, the guard window boundary, and the interval spacing for each acknowledge position. The same holds for the effects of second edges and held levels, and for the full-pulse recovery after a manual hold.

// File: rtl/wdt_pkg.sv
// Shared types for the wake watchdog.
package wdt_pkg;
    // Controller phases: startup, manual hold, host reset pulse, counting.
    typedef enum logic [1:0] {
        WD_BOOT   = 2'd0,
        WD_HOLD   = 2'd1,
        WD_RPULSE = 2'd2,
        WD_RUN    = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdt_ack_edge.sv
// Acknowledge edge detector.
// Flags one clock where done_in goes 0 -> 1. Assumes done_in is already
// synchronized to clk. During reset the history is preset high so that a
// level present at release is not seen as an edge.
module wdt_ack_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic done_in,
    output logic edge_o
);
    logic done_q;

    // Keep the previous sample of the acknowledge input.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b1;
        else        done_q <= done_in;
    end

    assign edge_o = done_in && !done_q;

    // R5
    no_level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_in && $past(done_in)) |-> !edge_o);
endmodule

// File: rtl/wdt_period_counter.sv
// Interval position counter.
// Counts ticks from 0 to len-1 while run is high and wraps to 0. Reports
// the boundary tick, the tick that ends the wake pulse and whether the
// acknowledge window is still open. Assumes len > WAKE_TICKS + GUARD_TICKS.
module wdt_period_counter #(
    parameter int CNT_W       = 16,
    parameter int WAKE_TICKS  = 2,
    parameter int GUARD_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    output logic             wrap,
    output logic             wake_end,
    output logic             ack_open
);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_TICKS - 1);
    localparam logic [CNT_W-1:0] GUARD_W   = CNT_W'(GUARD_TICKS);

    logic [CNT_W-1:0] pos;

    assign wrap     = run && tick && (pos == len - ONE);
    assign wake_end = run && tick && (pos == WAKE_LAST);
    assign ack_open = (pos < len - GUARD_W);

    // Advance the position on each tick, wrapping at the interval end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pos <= '0;
        else if (run && tick) pos <= wrap ? '0 : pos + ONE;
    end

    // R11
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pos < len));
endmodule

// File: rtl/wdt_rst_timer.sv
// Host reset pulse timer.
// Counts RESET_TICKS ticks while run is high and flags the last one.
// Held at zero whenever clr is high.
module wdt_rst_timer #(
    parameter int RESET_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done_o
);
    localparam int RW = $clog2(RESET_TICKS + 1);
    localparam logic [RW-1:0] LAST = RW'(RESET_TICKS - 1);
    localparam logic [RW-1:0] ONE  = RW'(1);
    localparam logic [RW-1:0] LIM  = RW'(RESET_TICKS);

    logic [RW-1:0] cnt;

    assign done_o = run && tick && (cnt == LAST);

    // Count pulse ticks; restart after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)    cnt <= '0;
        else if (done_o)      cnt <= '0;
        else if (run && tick) cnt <= cnt + ONE;
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < LIM);
endmodule

// File: rtl/wake_watchdog.sv
// Periodic wake watchdog controller (top).
// Issues a wake pulse at each interval boundary that follows an
// acknowledged interval, and drives an active-low host reset pulse when
// an interval ends unacknowledged. Assumes tick_en is a single-clock
// enable and interval_len > WAKE_TICKS + GUARD_TICKS when captured.
module wake_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int WAKE_TICKS  = 2,
    parameter int GUARD_TICKS = 2,
    parameter int RESET_TICKS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] interval_len,
    input  logic             done_in,
    input  logic             startup_busy,
    input  logic             mr_hold,
    output logic             wake_o,
    output logic             host_rst_n_o
);
    wd_state_e        state;
    logic [CNT_W-1:0] len_q;
    logic             acked;
    logic             wake_r;
    logic             ack_edge, wrap, wake_end, ack_open, rst_done;
    logic             in_run, in_pulse, force_idle, ack_take;

    assign in_run     = (state == WD_RUN);
    assign in_pulse   = (state == WD_RPULSE);
    assign force_idle = startup_busy || mr_hold;
    assign ack_take   = ack_edge && in_run && ack_open && !acked && !force_idle;

    wdt_ack_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_in (done_in),
        .edge_o  (ack_edge)
    );

    wdt_period_counter #(
        .CNT_W       (CNT_W),
        .WAKE_TICKS  (WAKE_TICKS),
        .GUARD_TICKS (GUARD_TICKS)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!in_run || force_idle),
        .run      (in_run),
        .tick     (tick_en),
        .len      (len_q),
        .wrap     (wrap),
        .wake_end (wake_end),
        .ack_open (ack_open)
    );

    wdt_rst_timer #(
        .RESET_TICKS (RESET_TICKS)
    ) u_rtimer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!in_pulse || force_idle),
        .run    (in_pulse),
        .tick   (tick_en),
        .done_o (rst_done)
    );

    // Phase sequencing, supervision flag, wake output and length capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WD_BOOT;
            len_q  <= '0;
            acked  <= 1'b0;
            wake_r <= 1'b0;
        end else begin
            if (state == WD_BOOT && !startup_busy) len_q <= interval_len;
            if (startup_busy) begin
                state  <= WD_BOOT;
                acked  <= 1'b0;
                wake_r <= 1'b0;
            end else if (mr_hold) begin
                state  <= WD_HOLD;
                acked  <= 1'b0;
                wake_r <= 1'b0;
            end else begin
                case (state)
                    WD_BOOT: begin
                        state <= WD_RUN;
                        acked <= 1'b0;
                    end
                    WD_HOLD: state <= WD_RPULSE;
                    WD_RPULSE: begin
                        if (rst_done) begin
                            state <= WD_RUN;
                            acked <= 1'b0;
                        end
                    end
                    WD_RUN: begin
                        if (wrap) begin
                            if (acked) begin
                                wake_r <= 1'b1;
                                acked  <= 1'b0;
                            end else begin
                                state  <= WD_RPULSE;
                                wake_r <= 1'b0;
                            end
                        end else if (ack_take) begin
                            acked  <= 1'b1;
                            wake_r <= 1'b0;
                        end else if (wake_end) begin
                            wake_r <= 1'b0;
                        end
                    end
                    default: state <= WD_BOOT;
                endcase
            end
        end
    end

    assign wake_o       = wake_r;
    assign host_rst_n_o = in_run;

    // R2
    busy_holds_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        startup_busy |=> !host_rst_n_o);

    // R2
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WD_BOOT) |=> $stable(len_q));

    // R10
    mr_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_hold && !startup_busy) |=> (!wake_o && !host_rst_n_o));

    // R4
    wake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> host_rst_n_o);

    // R3
    wake_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(acked));

    // R7
    ack_drops_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> !wake_o);
endmodule

// File: tb/sim_wake_watchdog.sv
// Bench for wake_watchdog: table of interval scenarios, then directed cases.
module sim_wake_watchdog;
    localparam int CNT_W = 16;
    localparam int L     = 8;
    localparam int RT    = 32;
    localparam int WT    = 2;
    localparam int NONE  = 15;

    // Row fields: [5:2] acknowledge position (15 = none), [1] second edge,
    // [0] expected wake (1) or reset (0) at the boundary.
    localparam logic [5:0] VEC [8] = '{
        {4'd3,  1'b0, 1'b1},
        {4'd0,  1'b0, 1'b1},
        {4'd5,  1'b1, 1'b1},
        {4'd6,  1'b0, 1'b0},
        {4'd1,  1'b0, 1'b1},
        {4'd15, 1'b0, 1'b0},
        {4'd2,  1'b1, 1'b1},
        {4'd4,  1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n, tick_en, done_in, startup_busy, mr_hold;
    logic [CNT_W-1:0] interval_len;
    logic wake_o, host_rst_n_o;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wake_watchdog #(.CNT_W(CNT_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .interval_len (interval_len),
        .done_in      (done_in),
        .startup_busy (startup_busy),
        .mr_hold      (mr_hold),
        .wake_o       (wake_o),
        .host_rst_n_o (host_rst_n_o)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk) done_in = 1'b1;
        @(negedge clk) done_in = 1'b0;
    endtask

    // One interval of len ticks with an acknowledge at position ack_at.
    task automatic run_interval(input int len, input int ack_at, input bit dbl, input bit start_wake);
        check(wake_o, start_wake, start_wake ? "R4" : "R3", "wake at interval start");
        for (int p = 0; p < len; p++) begin
            if (start_wake && p == 1 && ack_at > 1) check(wake_o, 1'b1, "R4", "wake still high");
            if (p == WT && ack_at >= WT) check(wake_o, 1'b0, "R4", "wake ended");
            if (p == ack_at) begin
                pulse_done();
                if (p < WT) check(wake_o, 1'b0, "R7", "early wake drop");
            end
            if (dbl && p == ack_at + 1) pulse_done();
            if (p == len - 1) begin
                check(wake_o, 1'b0, "R11", "no early boundary");
                check(host_rst_n_o, 1'b1, "R11", "released in interval");
            end
            tick_once();
        end
    endtask

    // Reset pulse of RT ticks after a missed interval or a manual hold.
    task automatic reset_phase(input bit raise_done);
        for (int k = 1; k <= RT; k++) begin
            if (raise_done && k == 10) done_in = 1'b1;
            tick_once();
            if (k == RT - 1) check(host_rst_n_o, 1'b0, "R9", "reset held");
            if (k == RT)     check(host_rst_n_o, 1'b1, "R9", "reset released");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit sw;
        rst_n = 1'b0; tick_en = 1'b0; done_in = 1'b0;
        startup_busy = 1'b1; mr_hold = 1'b0; interval_len = CNT_W'(L);
        repeat (3) @(negedge clk);
        check(wake_o, 1'b0, "R1", "wake in reset");
        check(host_rst_n_o, 1'b0, "R1", "host reset in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(host_rst_n_o, 1'b0, "R2", "held while busy");
        startup_busy = 1'b0;
        repeat (2) @(negedge clk);
        interval_len = CNT_W'(3);   // R2: ignored after capture
        check(host_rst_n_o, 1'b1, "R2", "released after startup");

        // Table walk
        sw = 1'b0;
        for (int i = 0; i < 8; i++) begin
            int  a;
            bit  d, ex;
            a  = int'(VEC[i][5:2]);
            d  = VEC[i][1];
            ex = VEC[i][0];
            run_interval(L, a, d, sw);
            check(wake_o, ex, ex ? "R6" : "R8", "boundary wake");
            check(host_rst_n_o, ex, ex ? "R11" : "R9", "boundary reset");
            if (!ex) begin
                reset_phase(1'b0);
                sw = 1'b0;
            end else begin
                sw = 1'b1;
            end
        end

        // R5: held level and edges during reset do not acknowledge
        run_interval(L, NONE, 1'b0, sw);
        check(host_rst_n_o, 1'b0, "R9", "missed interval");
        reset_phase(1'b1);
        run_interval(L, NONE, 1'b0, 1'b0);
        check(host_rst_n_o, 1'b0, "R5", "level not an acknowledge");
        check(wake_o, 1'b0, "R5", "no wake on level");
        done_in = 1'b0;
        reset_phase(1'b0);

        // R10: manual hold while wake high
        run_interval(L, 2, 1'b0, 1'b0);
        check(wake_o, 1'b1, "R4", "wake before hold");
        @(negedge clk) mr_hold = 1'b1;
        @(negedge clk);
        check(wake_o, 1'b0, "R10", "wake forced low");
        check(host_rst_n_o, 1'b0, "R10", "reset forced low");
        repeat (3) tick_once();
        check(host_rst_n_o, 1'b0, "R10", "reset held during hold");
        mr_hold = 1'b0;
        reset_phase(1'b0);
        run_interval(L, 1, 1'b0, 1'b0);
        check(wake_o, 1'b1, "R10", "wake after recovery");

        // R2: restart startup with a new length
        @(negedge clk) startup_busy = 1'b1;
        @(negedge clk);
        check(host_rst_n_o, 1'b0, "R2", "reset on busy");
        interval_len = CNT_W'(5);
        startup_busy = 1'b0;
        repeat (2) @(negedge clk);
        run_interval(5, 1, 1'b0, 1'b0);
        check(wake_o, 1'b1, "R2", "new length captured");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule